// File: doc/BRIEF.md
# External Bus Handover Controller

This block decides when the local side of an external bus gives the bus to another master and when it takes the bus back. Another master asks for the bus with an asynchronous request line. The local access sequencer reports whether a bus cycle is under way. That report includes the idle cycles inserted between back-to-back accesses, even though no chip-select is active during them. The bus is handed over only at a cycle boundary. If the bus is quiet when the request arrives, it is handed over at once. If it is busy, the handover waits until the current activity ends.

To avoid contention on the shared control lines, the block does two things. Before it lets go, it drives every control line to its inactive level for one clock and only then tri-states it. When the bus comes back, it first drives the lines inactive for one clock and only then passes the sequencer's values through. The acknowledge is raised only while the lines are tri-stated. A hold output stops the local sequencer from starting a new access during the whole handover.

Top module: `bus_handover_ctrl`

## Requirements
- R1: The request input passes through two flip-flops before it is used. A request driven between clock edges can first raise `hold_o` after the second rising edge that follows it, and not before.
- R2: With the bus idle (`cycle_busy_i` low), the third rising edge after the request starts a one-clock negate phase. During that phase `ctrl_oe_o` stays all ones and `ctrl_o` equals the `IDLE_LVL` parameter (default 4'hF).
- R3: While `cycle_busy_i` is high (a visible cycle or an inserted idle cycle), no handover starts. The negate phase begins on the first edge at which the synchronized request is high and `cycle_busy_i` is low.
- R4: Exactly one clock after the negate phase begins, `ctrl_oe_o` goes to all zeros (tri-stated).
- R5: `bus_ack_o` is 1 only while `ctrl_oe_o` is all zeros, and is 1 for every cycle of that state.
- R6: When the request is removed, the third rising edge after removal drops `bus_ack_o` and starts a one-clock regain phase. During that phase `ctrl_oe_o` is all ones and `ctrl_o` equals `IDLE_LVL`. On the next edge the block returns to normal operation.
- R7: `hold_o` is 1 whenever the block is not in normal operation. It is also 1 in a normal-operation cycle in which the synchronized request is high and `cycle_busy_i` is low.
- R8: In normal operation `ctrl_oe_o` is all ones and `ctrl_o` follows `ctrl_drive_i` in the same cycle. While the bus is handed over, `ctrl_drive_i` and `cycle_busy_i` have no effect on `ctrl_o`, `ctrl_oe_o` or `bus_ack_o`.
- R9: While `rst_n` is low, and directly after reset, the block is in normal operation: `bus_ack_o` is 0, `hold_o` is 0, `ctrl_oe_o` is all ones and the synchronizer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Asynchronous bus request from another master, active high |
| cycle_busy_i | input | 1 | A bus cycle or an inserted idle cycle is running |
| ctrl_drive_i | input | N_CTRL | Control-line levels wanted by the local sequencer |
| ctrl_o | output | N_CTRL | Control-line levels presented to the pads |
| ctrl_oe_o | output | N_CTRL | Per-line output enable, 1 = driven |
| bus_ack_o | output | 1 | Bus acknowledge, high while the lines are tri-stated |
| hold_o | output | 1 | Stops the local sequencer from starting an access |

## Verification
A request is first felt two edges after it is driven (R1). The negate phase starts on edge max(3, B+1), where B is the number of edges at which busy was sampled high. Tri-state and acknowledge follow one edge later. On removal of the request, the regain phase comes on the third edge and normal drive on the fourth. The bench computes these edge numbers from the table entry for each handover. It moves inputs and samples every output on the falling edge after each rising edge, so each check falls in the exact cycle the requirements predict. Directed cases cover reset, inputs that change during the handover, and a reset taken while the bus is handed over.

// File: rtl/bho_pkg.sv
package bho_pkg;

  typedef enum logic [1:0] {
    ST_OWNED      = 2'd0,
    ST_NEG_REL    = 2'd1,
    ST_RELEASED   = 2'd2,
    ST_NEG_REGAIN = 2'd3
  } bho_state_e;

endpackage

// File: rtl/bho_req_sync.sv
module bho_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async_i,
  output logic req_sync_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;
  logic [LAST:0] stage_d;

  // shift chain toward the used end
  generate
    if (STAGES == 1) begin : g_single
      assign stage_d = req_async_i;
    end else begin : g_chain
      assign stage_d = {stage_q[LAST-1:0], req_async_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign req_sync_o = stage_q[LAST];

  // R1: the used output only repeats the older stage (no direct path)
  a_r1_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES > 1) |=> (req_sync_o == $past(stage_q[LAST-((STAGES>1)?1:0)])));

endmodule

// File: rtl/bho_fsm.sv
module bho_fsm
  import bho_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s_i,
  input  logic       cycle_busy_i,
  output bho_state_e state_o,
  output logic       hold_o
);
  bho_state_e state_q, state_d;
  logic       go_release;

  assign go_release = req_s_i & ~cycle_busy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWNED:      if (go_release) state_d = ST_NEG_REL;
      ST_NEG_REL:    state_d = ST_RELEASED;
      ST_RELEASED:   if (!req_s_i) state_d = ST_NEG_REGAIN;
      ST_NEG_REGAIN: state_d = ST_OWNED;
      default:       state_d = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OWNED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign hold_o  = (state_q != ST_OWNED) | (state_q == ST_OWNED & go_release);

  // R3: a running cycle keeps the bus owned
  a_r3_wait_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OWNED && cycle_busy_i) |=> (state_q == ST_OWNED));
  // R4: negate-before-release lasts exactly one clock
  a_r4_one_negate: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NEG_REL) |=> (state_q == ST_RELEASED));
  // R6: regain negate lasts exactly one clock
  a_r6_one_regain: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NEG_REGAIN) |=> (state_q == ST_OWNED));
  // R7: sequencer held whenever not in normal operation
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_OWNED) |-> hold_o);

endmodule

// File: rtl/bho_ctrl_out.sv
module bho_ctrl_out
  import bho_pkg::*;
#(
  parameter int              N_CTRL   = 4,
  parameter logic [N_CTRL-1:0] IDLE_LVL = '1
) (
  input  bho_state_e        state_i,
  input  logic [N_CTRL-1:0] drive_i,
  output logic [N_CTRL-1:0] ctrl_o,
  output logic [N_CTRL-1:0] oe_o,
  output logic              ack_o
);
  logic pass, enable;

  assign pass   = (state_i == ST_OWNED);
  assign enable = (state_i != ST_RELEASED);
  assign ack_o  = (state_i == ST_RELEASED);

  generate
    for (genvar i = 0; i < N_CTRL; i++) begin : g_line
      assign ctrl_o[i] = pass ? drive_i[i] : IDLE_LVL[i];
      assign oe_o[i]   = enable;
    end
  endgenerate

endmodule

// File: rtl/bus_handover_ctrl.sv
module bus_handover_ctrl
  import bho_pkg::*;
#(
  parameter int                N_CTRL      = 4,
  parameter logic [N_CTRL-1:0] IDLE_LVL    = '1,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req_i,
  input  logic              cycle_busy_i,
  input  logic [N_CTRL-1:0] ctrl_drive_i,
  output logic [N_CTRL-1:0] ctrl_o,
  output logic [N_CTRL-1:0] ctrl_oe_o,
  output logic              bus_ack_o,
  output logic              hold_o
);
  localparam logic [N_CTRL-1:0] ALL_ON = '1;

  logic       req_s;
  bho_state_e state;

  bho_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_async_i(bus_req_i), .req_sync_o(req_s)
  );

  bho_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s_i(req_s), .cycle_busy_i(cycle_busy_i),
    .state_o(state), .hold_o(hold_o)
  );

  bho_ctrl_out #(.N_CTRL(N_CTRL), .IDLE_LVL(IDLE_LVL)) u_out (
    .state_i(state), .drive_i(ctrl_drive_i),
    .ctrl_o(ctrl_o), .oe_o(ctrl_oe_o), .ack_o(bus_ack_o)
  );

  // R5: acknowledge only with lines tri-stated
  a_r5_ack_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack_o |-> (ctrl_oe_o == '0));
  // R2: lines were at inactive level just before tri-state
  a_r2_negate_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_oe_o == '0 && $past(ctrl_oe_o) == ALL_ON) |-> ($past(ctrl_o) == IDLE_LVL));
  // R6: first driven cycle after regain is inactive
  a_r6_regain_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_oe_o == ALL_ON && $past(ctrl_oe_o) == '0) |-> (ctrl_o == IDLE_LVL && !bus_ack_o));
  // R8: output enables move together
  a_r8_oe_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_oe_o == '0) || (ctrl_oe_o == ALL_ON));

endmodule

// File: tb/bus_handover_ctrl_tb.sv
module bus_handover_ctrl_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          N = 4;
  localparam logic [N-1:0] IDLE = 4'hF;
  localparam logic [N-1:0] ON   = 4'hF;
  localparam int          NV = 6;
  // entry: {drive pattern[3:0], busy edge count[7:0]}
  localparam logic [11:0] VEC [NV] = '{
    {4'h0, 8'd0}, {4'h5, 8'd1}, {4'hA, 8'd2},
    {4'h3, 8'd3}, {4'hC, 8'd5}, {4'h6, 8'd9}
  };

  logic clk = 0, rst_n = 0, req = 0, busy = 0;
  logic [N-1:0] drive = '0;
  logic [N-1:0] ctrl, oe;
  logic ack, hold;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_handover_ctrl #(.N_CTRL(N), .IDLE_LVL(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req_i(req), .cycle_busy_i(busy),
    .ctrl_drive_i(drive), .ctrl_o(ctrl), .ctrl_oe_o(oe),
    .bus_ack_o(ack), .hold_o(hold)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic all_outputs(string tag, logic [N-1:0] ec, logic [N-1:0] eo,
                             logic ea, logic eh);
    chk({tag, " ctrl"}, 32'(ctrl), 32'(ec));
    chk({tag, " oe"},   32'(oe),   32'(eo));
    chk({tag, " ack"},  32'(ack),  32'(ea));
    chk({tag, " hold"}, 32'(hold), 32'(eh));
  endtask

  task automatic handover(logic [N-1:0] d, int blen);
    int edec;
    edec = (blen + 1 > 3) ? blen + 1 : 3;
    @(negedge clk);
    drive = d; req = 1; busy = (blen > 0);
    for (int n = 1; n <= edec + 3; n++) begin
      @(negedge clk);
      busy = (n < blen);
      #1;
      if (n < edec)
        all_outputs("R1 R3 R7 R8 owned", d, ON, 0, (n >= 2) && !(n < blen));
      else if (n == edec)
        all_outputs("R2 R3 negate", IDLE, ON, 0, 1);
      else
        all_outputs("R4 R5 released", IDLE, '0, 1, 1);
    end
    req = 0;
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk); #1;
      if (n < 3)      all_outputs("R6 still released", IDLE, '0, 1, 1);
      else if (n == 3) all_outputs("R6 regain negate", IDLE, ON, 0, 1);
      else             all_outputs("R6 R8 back owned", d, ON, 0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    drive = 4'h9; #1;
    all_outputs("R9 in reset", 4'h9, ON, 0, 0);
    rst_n = 1;
    @(negedge clk); #1;
    all_outputs("R9 after reset", 4'h9, ON, 0, 0);

    for (int v = 0; v < NV; v++)
      handover(VEC[v][11:8], int'(VEC[v][7:0]));

    // R8: inputs ignored while handed over
    @(negedge clk); req = 1;
    repeat (4) @(negedge clk);
    drive = 4'h0; busy = 1; #1;
    all_outputs("R8 drive ignored", IDLE, '0, 1, 1);
    @(negedge clk); drive = 4'h7; #1;
    all_outputs("R8 busy ignored", IDLE, '0, 1, 1);

    // R9: reset while handed over
    @(negedge clk); rst_n = 0; busy = 0; #1;
    all_outputs("R9 reset during release", 4'h7, ON, 0, 0);
    req = 0;
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk); #1;
    all_outputs("R9 owned after reset", 4'h7, ON, 0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule